// File: doc/BRIEF.md
# Three-Port Series Scattering Junction

This block is a fixed-point series junction for a wave-domain circuit simulator built as a binary tree. It has three ports. One port faces the root and is made reflection-free. The other two ports connect to child elements, and a child may itself be another junction of the same kind. The resistance the block presents toward the root is the sum of the two child resistances, so the wave it sends upward never depends on the wave that later comes back down. A sequencer can therefore run every sample as a sweep from the leaves to the root, and then a sweep from the root back to the leaves.

In the up pass, the block takes the waves reflected by its two children and produces the wave it sends to its parent. In the down pass, it takes the wave arriving from the parent and splits it into one returning wave per child. The split is weighted by each child's share of the total resistance. Those shares are fixed-point ratios that the block recomputes and registers every cycle from the live child resistances. Every result clamps to the wave range instead of wrapping. A one-cycle done pulse follows each pass, so passes can be chained through a tree.

Top module: `wdf_series_adaptor`

## Requirements
- R1: After reset, `wave_up`, `wave_down_left`, `wave_down_right`, `res_port`, `up_done` and `down_done` are all zero.
- R2: `res_port` equals the unsigned sum `res_left + res_right`, 17 bits wide, one cycle after the resistances are presented.
- R3: One clock edge after the edge that samples `up_start` high, `wave_up` holds the saturated value of −(`wave_in_left` + `wave_in_right`) as sampled at that edge.
- R4: `up_done` is high for exactly the cycle after each cycle in which `up_start` is sampled high, and low otherwise. `down_done` follows `down_start` in the same way.
- R5: Each child ratio is a 17-bit Q1.16 value equal to floor(R_k·65536 / (res_left + res_right)), where R_k is that child's resistance, and it is 0 when the total is 0. The ratios take effect one cycle after the resistances change.
- R6: One edge after `down_start` is sampled high, each down wave equals sat(a_k − floor(c_k · s / 65536)). Here s = `wave_from_root` + a_left + a_right, c_k is the child's ratio, and a_k are the child waves latched by the most recent earlier `up_start`, not the current `wave_in_*` values.
- R7: All wave outputs are signed two's complement in 16 bits and saturate to −32768 or +32767 when the exact result lies outside that range.
- R8: `wave_up` changes only after an `up_start`, and the two down waves change only after a `down_start`. An up pass leaves the down waves untouched, and a down pass leaves `wave_up` untouched.
- R9: Whenever the total resistance is non-zero, the two ratios sum to 65536 or 65535. As a result, with both latched child waves at zero, −(`wave_down_left` + `wave_down_right`) lies within two of the root wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_left | input | 16 | Port resistance of the left child (unsigned) |
| res_right | input | 16 | Port resistance of the right child (unsigned) |
| res_port | output | 17 | Registered adapted-port resistance presented to the parent |
| up_start | input | 1 | Starts an up pass with the current child waves |
| wave_in_left | input | 16 | Signed wave reflected by the left child |
| wave_in_right | input | 16 | Signed wave reflected by the right child |
| wave_up | output | 16 | Signed reflection-free wave sent toward the root |
| up_done | output | 1 | One-cycle pulse after an up pass |
| down_start | input | 1 | Starts a down pass with the current root wave |
| wave_from_root | input | 16 | Signed wave arriving from the parent |
| wave_down_left | output | 16 | Signed wave returned to the left child |
| wave_down_right | output | 16 | Signed wave returned to the right child |
| down_done | output | 1 | One-cycle pulse after a down pass |

## Verification
The hardest situation to reach is a down pass that must draw on child waves latched earlier rather than on the values present on the child inputs at that moment. The stimulus therefore drives fresh random values onto the child inputs between the up pass and the down pass. It also issues back-to-back down passes with no up pass between them. Saturation of the scattered waves needs a root wave and child waves of opposite sign near full scale, together with a lopsided resistance split. Directed cases supply these, and they also cover zero total resistance and one child of zero resistance.

// File: rtl/wdf_adaptor_pkg.sv
package wdf_adaptor_pkg;
   // Rounding applied when the resistance ratios are formed
   typedef enum logic {
      RND_FLOOR   = 1'b0,
      RND_NEAREST = 1'b1
   } rnd_mode_e;
endpackage

// File: rtl/wdf_sat.sv
module wdf_sat #(
   parameter int IN_W  = 20,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int PAD_W = IN_W - OUT_W + 1;
   localparam logic signed [IN_W-1:0] MAX_V = $signed({{PAD_W{1'b0}}, {(OUT_W-1){1'b1}}});
   localparam logic signed [IN_W-1:0] MIN_V = $signed({{PAD_W{1'b1}}, {(OUT_W-1){1'b0}}});

   if (IN_W <= OUT_W) begin : g_bad_width
      $error("wdf_sat: IN_W must exceed OUT_W");
   end

   always_comb begin
      if (din > MAX_V)      dout = MAX_V[OUT_W-1:0];
      else if (din < MIN_V) dout = MIN_V[OUT_W-1:0];
      else                  dout = din[OUT_W-1:0];
   end
endmodule

// File: rtl/wdf_ratio_q.sv
module wdf_ratio_q
   import wdf_adaptor_pkg::*;
#(
   parameter int        NUM_W = 16,
   parameter int        FRAC  = 16,
   parameter rnd_mode_e ROUND = RND_FLOOR
) (
   input  logic [NUM_W-1:0] num,
   input  logic [NUM_W:0]   den,
   output logic [FRAC:0]    ratio
);
   localparam int DIV_W = NUM_W + FRAC + 2;
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC;

   logic [DIV_W-1:0] dividend, divisor, bias, quot;

   if (FRAC < 4 || FRAC > 24) begin : g_bad_frac
      $error("wdf_ratio_q: FRAC out of range");
   end

   assign divisor = {{(DIV_W-NUM_W-1){1'b0}}, den};

   if (ROUND == RND_NEAREST) begin : g_nearest
      assign bias = divisor >> 1;
   end else begin : g_floor
      assign bias = '0;
   end

   assign dividend = ({{(FRAC+2){1'b0}}, num} << FRAC) + bias;

   always_comb begin
      if (den == '0) quot = '0;
      else           quot = dividend / divisor;
   end

   // a ratio of a part to its own sum never exceeds one
   assign ratio = (quot > ONE) ? ONE[FRAC:0] : quot[FRAC:0];
endmodule

// File: rtl/wdf_scatter_leg.sv
module wdf_scatter_leg #(
   parameter int WAVE_W = 16,
   parameter int FRAC   = 16
) (
   input  logic signed [WAVE_W-1:0] a_child,
   input  logic signed [WAVE_W+1:0] node_sum,
   input  logic        [FRAC:0]     coef,
   output logic signed [WAVE_W-1:0] b_child
);
   localparam int SUM_W  = WAVE_W + 2;
   localparam int PROD_W = SUM_W + FRAC + 2;

   logic signed [PROD_W-1:0] coef_x, sum_x, a_x, prod, scaled, diff;

   assign coef_x = $signed({{(PROD_W-FRAC-1){1'b0}}, coef});
   assign sum_x  = {{(PROD_W-SUM_W){node_sum[SUM_W-1]}}, node_sum};
   assign a_x    = {{(PROD_W-WAVE_W){a_child[WAVE_W-1]}}, a_child};
   assign prod   = coef_x * sum_x;
   assign scaled = prod >>> FRAC;       // floor division by 2^FRAC
   assign diff   = a_x - scaled;

   wdf_sat #(.IN_W(PROD_W), .OUT_W(WAVE_W)) sat_i (
      .din (diff),
      .dout(b_child)
   );
endmodule

// File: rtl/wdf_series_adaptor.sv
module wdf_series_adaptor
   import wdf_adaptor_pkg::*;
#(
   parameter int        WAVE_W    = 16,
   parameter int        RES_W     = 16,
   parameter int        COEF_FRAC = 16,
   parameter rnd_mode_e ROUND     = RND_FLOOR
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [RES_W-1:0]         res_left,
   input  logic [RES_W-1:0]         res_right,
   output logic [RES_W:0]           res_port,
   input  logic                     up_start,
   input  logic signed [WAVE_W-1:0] wave_in_left,
   input  logic signed [WAVE_W-1:0] wave_in_right,
   output logic signed [WAVE_W-1:0] wave_up,
   output logic                     up_done,
   input  logic                     down_start,
   input  logic signed [WAVE_W-1:0] wave_from_root,
   output logic signed [WAVE_W-1:0] wave_down_left,
   output logic signed [WAVE_W-1:0] wave_down_right,
   output logic                     down_done
);
   localparam int SUM_W  = WAVE_W + 2;
   localparam int COEF_W = COEF_FRAC + 1;
   localparam int PORT_W = RES_W + 1;
   localparam int LEGS   = 2;
   localparam logic [COEF_W:0] UNITY = (COEF_W+1)'(1) << COEF_FRAC;

   if (WAVE_W < 4 || WAVE_W > 32) begin : g_bad_wave
      $error("wdf_series_adaptor: WAVE_W out of range");
   end
   if (RES_W < 2 || RES_W > 32) begin : g_bad_res
      $error("wdf_series_adaptor: RES_W out of range");
   end

   logic [RES_W-1:0]         res_child [LEGS];
   logic [COEF_W-1:0]        coef_d    [LEGS];
   logic [COEF_W-1:0]        coef_q    [LEGS];
   logic signed [WAVE_W-1:0] a_in      [LEGS];
   logic signed [WAVE_W-1:0] a_q       [LEGS];
   logic signed [WAVE_W-1:0] b_d       [LEGS];
   logic signed [WAVE_W-1:0] b_q       [LEGS];

   logic [PORT_W-1:0]        res_sum, res_port_q;
   logic signed [SUM_W-1:0]  up_neg, node_sum;
   logic signed [WAVE_W-1:0] up_sat, wave_up_q;
   logic                     up_done_q, down_done_q;

   assign res_child[0] = res_left;
   assign res_child[1] = res_right;
   assign a_in[0]      = wave_in_left;
   assign a_in[1]      = wave_in_right;

   // adapted port: R1 = R2 + R3
   assign res_sum = {1'b0, res_left} + {1'b0, res_right};

   // reflection-free wave toward the root
   assign up_neg = -({{2{wave_in_left[WAVE_W-1]}},  wave_in_left} +
                     {{2{wave_in_right[WAVE_W-1]}}, wave_in_right});

   wdf_sat #(.IN_W(SUM_W), .OUT_W(WAVE_W)) up_sat_i (
      .din (up_neg),
      .dout(up_sat)
   );

   // incident-wave total seen by the junction during the down pass
   assign node_sum = {{2{wave_from_root[WAVE_W-1]}}, wave_from_root} +
                     {{2{a_q[0][WAVE_W-1]}}, a_q[0]} +
                     {{2{a_q[1][WAVE_W-1]}}, a_q[1]};

   for (genvar k = 0; k < LEGS; k++) begin : g_leg
      wdf_ratio_q #(.NUM_W(RES_W), .FRAC(COEF_FRAC), .ROUND(ROUND)) ratio_i (
         .num  (res_child[k]),
         .den  (res_sum),
         .ratio(coef_d[k])
      );
      wdf_scatter_leg #(.WAVE_W(WAVE_W), .FRAC(COEF_FRAC)) leg_i (
         .a_child (a_q[k]),
         .node_sum(node_sum),
         .coef    (coef_q[k]),
         .b_child (b_d[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_port_q  <= '0;
         wave_up_q   <= '0;
         up_done_q   <= 1'b0;
         down_done_q <= 1'b0;
         for (int k = 0; k < LEGS; k++) begin
            coef_q[k] <= '0;
            a_q[k]    <= '0;
            b_q[k]    <= '0;
         end
      end else begin
         res_port_q  <= res_sum;
         up_done_q   <= up_start;
         down_done_q <= down_start;
         for (int k = 0; k < LEGS; k++) coef_q[k] <= coef_d[k];
         if (up_start) begin
            wave_up_q <= up_sat;
            for (int k = 0; k < LEGS; k++) a_q[k] <= a_in[k];
         end
         if (down_start) begin
            for (int k = 0; k < LEGS; k++) b_q[k] <= b_d[k];
         end
      end
   end

   assign res_port        = res_port_q;
   assign wave_up         = wave_up_q;
   assign up_done         = up_done_q;
   assign wave_down_left  = b_q[0];
   assign wave_down_right = b_q[1];
   assign down_done       = down_done_q;

   // ---------------------------------------------------------------- checks
   p_res_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> res_port == ({1'b0, $past(res_left)} + {1'b0, $past(res_right)}));

   p_up_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      up_start |=> up_done);

   p_up_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !up_start |=> !up_done);

   p_down_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      down_start |=> down_done);

   p_down_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !down_start |=> !down_done);

   p_up_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !up_start |=> $stable(wave_up));

   p_down_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !down_start |=> ($stable(wave_down_left) && $stable(wave_down_right)));

   p_coef_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_port_q != '0) |->
         (({1'b0, coef_q[0]} + {1'b0, coef_q[1]}) == UNITY ||
          ({1'b0, coef_q[0]} + {1'b0, coef_q[1]}) == UNITY - 1'b1));
endmodule

// File: tb/wdf_series_adaptor_tb_top.sv
`timescale 1ns/1ps
module wdf_series_adaptor_tb_top;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] res_left = '0, res_right = '0;
   logic [16:0] res_port;
   logic up_start = 1'b0, down_start = 1'b0;
   logic signed [15:0] wave_in_left = '0, wave_in_right = '0, wave_from_root = '0;
   logic signed [15:0] wave_up, wave_down_left, wave_down_right;
   logic up_done, down_done;

   int checks = 0;
   int errors = 0;
   longint lat_l = 0, lat_r = 0;   // child waves the bench expects latched
   longint cur_rl = 0, cur_rr = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   wdf_series_adaptor dut_i (
      .clk, .rst_n, .res_left, .res_right, .res_port,
      .up_start, .wave_in_left, .wave_in_right, .wave_up, .up_done,
      .down_start, .wave_from_root, .wave_down_left, .wave_down_right, .down_done
   );

   function automatic longint sat(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint ratio(input longint r, input longint tot);
      if (tot == 0) return 0;
      return (r << 16) / tot;
   endfunction

   function automatic longint down_exp(input longint a, input longint r, input longint root);
      longint s, c;
      s = root + lat_l + lat_r;
      c = ratio(r, cur_rl + cur_rr);
      return sat(a - ((c * s) >>> 16));
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_res(input longint l, input longint r);
      res_left = 16'(l); res_right = 16'(r);
      cur_rl = l; cur_rr = r;
      @(negedge clk);
      chk("R2 res_port", longint'(res_port), l + r);
      @(negedge clk);
   endtask

   task automatic do_up(input longint a2, input longint a3);
      longint dl, dr;
      dl = longint'(wave_down_left); dr = longint'(wave_down_right);
      up_start = 1'b1; wave_in_left = 16'(a2); wave_in_right = 16'(a3);
      @(negedge clk);
      up_start = 1'b0;
      lat_l = a2; lat_r = a3;
      chk("R4 up_done high", longint'(up_done), 1);
      chk("R3/R7 wave_up", longint'(wave_up), sat(-(a2 + a3)));
      chk("R8 down_left held by up pass", longint'(wave_down_left), dl);
      chk("R8 down_right held by up pass", longint'(wave_down_right), dr);
      // scramble child inputs: the down pass must ignore them (R6)
      wave_in_left = 16'($urandom); wave_in_right = 16'($urandom);
      @(negedge clk);
      chk("R4 up_done low", longint'(up_done), 0);
   endtask

   task automatic do_down(input longint root);
      longint wu;
      wu = longint'(wave_up);
      down_start = 1'b1; wave_from_root = 16'(root);
      @(negedge clk);
      down_start = 1'b0;
      chk("R4 down_done high", longint'(down_done), 1);
      chk("R5/R6/R7 down_left", longint'(wave_down_left), down_exp(lat_l, cur_rl, root));
      chk("R5/R6/R7 down_right", longint'(wave_down_right), down_exp(lat_r, cur_rr, root));
      chk("R8 wave_up held by down pass", longint'(wave_up), wu);
      @(negedge clk);
      chk("R4 down_done low", longint'(down_done), 0);
   endtask

   function automatic longint rnd_wave();
      return longint'($signed(16'($urandom)));
   endfunction

   initial begin
      longint s, tot;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 wave_up", longint'(wave_up), 0);
      chk("R1 down_left", longint'(wave_down_left), 0);
      chk("R1 down_right", longint'(wave_down_right), 0);
      chk("R1 res_port", longint'(res_port), 0);
      chk("R1 up_done", longint'(up_done), 0);
      chk("R1 down_done", longint'(down_done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: zero total resistance gives zero ratios (R5)
      set_res(0, 0);
      do_up(1000, -300);
      do_down(5000);
      // equal split
      set_res(100, 100);
      do_up(1200, -400);
      do_down(-7000);
      // one child of zero resistance
      set_res(0, 4321);
      do_up(-32768, 32767);
      do_down(12345);
      // up-pass saturation both ways (R7)
      set_res(80, 1);
      do_up(-32768, -32768);
      do_up(32767, 32767);
      // down-pass saturation: lopsided split, large opposite-sign waves
      set_res(65535, 1);
      do_up(-32768, 32767);
      do_down(32767);
      do_up(32767, -32768);
      do_down(-32768);
      // repeated down pass reuses the same latched waves (R6)
      do_down(-32768);
      do_down(20000);
      // idle cycles leave outputs alone (R8)
      begin
         longint wu, dl, dr;
         wu = longint'(wave_up); dl = longint'(wave_down_left); dr = longint'(wave_down_right);
         wave_in_left = 16'sd999; wave_from_root = -16'sd999;
         repeat (3) @(negedge clk);
         chk("R8 idle wave_up", longint'(wave_up), wu);
         chk("R8 idle down_left", longint'(wave_down_left), dl);
         chk("R8 idle down_right", longint'(wave_down_right), dr);
      end
      // R9: with zero child waves the down waves split the root wave
      for (int i = 0; i < 20; i++) begin
         longint l, r;
         l = longint'($urandom_range(65535, 1)); r = longint'($urandom_range(65535, 0));
         set_res(l, r);
         do_up(0, 0);
         s = longint'($urandom_range(32767, 0));
         do_down(s);
         tot = -(longint'(wave_down_left) + longint'(wave_down_right));
         checks++;
         if (tot > s || tot < s - 2) begin
            errors++;
            $display("FAIL R9 ratio sum: actual %0d expected %0d..%0d", tot, s - 2, s);
         end
      end
      // constrained random
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(3, 0) == 0)
            set_res(longint'($urandom_range(65535, 0)), longint'($urandom_range(65535, 0)));
         do_up(rnd_wave(), rnd_wave());
         do_down(rnd_wave());
         if ($urandom_range(4, 0) == 0) do_down(rnd_wave());
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule